// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block turns one trellis step's worth of received soft symbols into the branch metrics a Viterbi add-compare-select array consumes. Each step brings three signed 3-bit soft values, nominally between -3 and +3, where a negative value leans toward a transmitted 0 and a positive value toward a transmitted 1. For each of the eight possible 3-bit codewords the block forms a signed metric. It uses only additions and subtractions of the three inputs, so a codeword that matches the received symbols better gets a smaller metric.

The metrics are offered in two forms. A registered parallel bus carries all eight 5-bit words and holds them until the next accepted step. A set of eight serial lines shifts each word out least significant bit first over five cycles, for a bit-serial add-compare-select array. A strobe marks the cycle that carries bit 0. Accepted steps may arrive every fifth cycle, and the serial stream then runs without gaps.

Top module: `soft_bmu`

## Requirements
- R1: For codeword index c (0 to 7), bit k of c pairs with input symk. The metric is the sum over k of -symk when that bit is 1 and +symk when it is 0. It appears as a 5-bit two's complement word on bm_par bits [5c+4:5c].
- R2: bm_par changes only in the cycle after a rising edge at which in_valid is high. While in_valid is low it holds its value, whatever the symbol inputs do.
- R3: The metric of codeword c is always the negation of the metric of codeword 7-c.
- R4: After an edge with in_valid high, ser_bits[c] presents bits 0, 1, 2, 3 and 4 of codeword c's metric in the following five cycles, one bit per cycle, least significant bit first.
- R5: ser_first is high in exactly the cycle that carries bit 0 of a new serial word, and low in every other cycle.
- R6: Once all five bits of a word have been sent and no new step has been accepted, every ser_bits line is 0.
- R7: An accepted step always starts a new serial word in the next cycle, even while an earlier word is still being sent. The rest of the earlier word is dropped. Steps accepted every fifth cycle give an unbroken stream.
- R8: A synchronous active-high rst clears bm_par, ser_bits and ser_first in the cycle after the edge at which it is sampled, even in the middle of a serial word.
- R9: The input code 100 (-4) is summed at face value with no saturation. All three inputs at -4 give -12 for codeword 0 and +12 for codeword 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the three symbols at this edge |
| sym0 | input | SYM_W | Soft value for codeword bit 0, two's complement |
| sym1 | input | SYM_W | Soft value for codeword bit 1, two's complement |
| sym2 | input | SYM_W | Soft value for codeword bit 2, two's complement |
| bm_par | output | 8*BM_W | Eight registered metrics, codeword c at [BM_W*c+BM_W-1:BM_W*c] |
| ser_bits | output | 8 | Current serial bit of each codeword's metric |
| ser_first | output | 1 | High when ser_bits carries bit 0 of a word |

## Verification
The functions that collide are the launch of a new serial word and the sending of the previous one. A step accepted while an earlier word is still leaving either follows its final bit directly or cuts it short. The bench provokes the first case by sweeping all 343 in-range symbol combinations with a step every fifth cycle. It provokes the second by accepting a step two cycles into a word, and it also asserts reset in the middle of a word. A behavioural model steps alongside the design on every clock and predicts each serial line, the strobe and the parallel bus. A mismatch in any cycle shows whether the old bit, the new bit or a zero won.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  // symbols per trellis step (one per codeword bit)
  localparam int N_SYM = 3;
  // number of distinct codewords
  localparam int N_CW  = 1 << N_SYM;
endpackage

// File: rtl/bmu_metric_calc.sv
module bmu_metric_calc #(
  parameter int                          SYM_W = 3,
  parameter int                          BM_W  = 5,
  parameter logic [bmu_pkg::N_SYM-1:0]   CODE  = '0
) (
  input  logic [bmu_pkg::N_SYM*SYM_W-1:0] syms,
  output logic [BM_W-1:0]                 metric
);
  localparam int EXT_W = BM_W - SYM_W;

  logic [SYM_W-1:0] raw;
  logic [BM_W-1:0]  ext;
  logic [BM_W-1:0]  acc;

  // signed sum: subtract a symbol when the codeword bit is 1, add it otherwise
  always_comb begin
    acc = '0;
    raw = '0;
    ext = '0;
    for (int k = 0; k < bmu_pkg::N_SYM; k++) begin
      raw = syms[k*SYM_W +: SYM_W];
      ext = {{EXT_W{raw[SYM_W-1]}}, raw};
      if (CODE[k]) acc = acc - ext;
      else         acc = acc + ext;
    end
  end

  assign metric = acc;
endmodule

// File: rtl/bmu_serializer.sv
module bmu_serializer #(
  parameter int BM_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BM_W-1:0] din,
  output logic            bit_o
);
  logic [BM_W-1:0] shreg;

  // load wins over shifting; zeros fill from the top so an idle line reads 0
  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= din;
    else           shreg <= {1'b0, shreg[BM_W-1:1]};
  end

  assign bit_o = shreg[0];
endmodule

// File: rtl/soft_bmu.sv
module soft_bmu #(
  parameter int SYM_W = 3,
  parameter int BM_W  = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [SYM_W-1:0]                sym0,
  input  logic [SYM_W-1:0]                sym1,
  input  logic [SYM_W-1:0]                sym2,
  output logic [bmu_pkg::N_CW*BM_W-1:0]   bm_par,
  output logic [bmu_pkg::N_CW-1:0]        ser_bits,
  output logic                            ser_first
);
  localparam int N_CW  = bmu_pkg::N_CW;
  localparam int N_SYM = bmu_pkg::N_SYM;

  logic [N_SYM*SYM_W-1:0] syms;
  logic [N_CW*BM_W-1:0]   metric_now;
  logic                   first_q;

  assign syms = {sym2, sym1, sym0};

  for (genvar c = 0; c < N_CW; c++) begin : g_cw
    bmu_metric_calc #(
      .SYM_W (SYM_W),
      .BM_W  (BM_W),
      .CODE  (N_SYM'(c))
    ) calc_i (
      .syms   (syms),
      .metric (metric_now[c*BM_W +: BM_W])
    );

    always_ff @(posedge clk) begin
      if (rst)           bm_par[c*BM_W +: BM_W] <= '0;
      else if (in_valid) bm_par[c*BM_W +: BM_W] <= metric_now[c*BM_W +: BM_W];
    end

    bmu_serializer #(
      .BM_W (BM_W)
    ) ser_i (
      .clk   (clk),
      .rst   (rst),
      .load  (in_valid),
      .din   (metric_now[c*BM_W +: BM_W]),
      .bit_o (ser_bits[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) first_q <= 1'b0;
    else     first_q <= in_valid;
  end

  assign ser_first = first_q;
endmodule

// File: rtl/soft_bmu_chk.sv
module soft_bmu_chk #(
  parameter int N_CW = 8,
  parameter int BM_W = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [N_CW*BM_W-1:0]   bm_par,
  input logic [N_CW-1:0]        ser_bits,
  input logic                   ser_first
);
  logic [N_CW-1:0] lsb_vec;
  logic            sym_ok;
  logic [2:0]      idle_cnt;
  logic [BM_W:0]   pair_sum;

  always_comb begin
    sym_ok   = 1'b1;
    lsb_vec  = '0;
    pair_sum = '0;
    for (int c = 0; c < N_CW; c++) begin
      lsb_vec[c] = bm_par[c*BM_W];
      pair_sum = {bm_par[c*BM_W+BM_W-1], bm_par[c*BM_W +: BM_W]}
               + {bm_par[(N_CW-1-c)*BM_W+BM_W-1], bm_par[(N_CW-1-c)*BM_W +: BM_W]};
      if (pair_sum != '0) sym_ok = 1'b0;
    end
  end

  // cycles since the last accepted step, saturating
  always_ff @(posedge clk) begin
    if (rst)                 idle_cnt <= 3'd7;
    else if (in_valid)       idle_cnt <= 3'd0;
    else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 3'd1;
  end

  // R8
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bm_par == '0 && ser_bits == '0 && !ser_first));

  // R2
  par_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(bm_par));

  // R5
  first_mark_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ser_first);

  // R4
  lsb_first_chk: assert property (@(posedge clk) disable iff (rst)
    ser_first |-> (ser_bits == lsb_vec));

  // R3
  mirror_pair_chk: assert property (@(posedge clk) disable iff (rst)
    sym_ok);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= 3'd5) |-> (ser_bits == '0 && !ser_first));
endmodule

bind soft_bmu soft_bmu_chk #(
  .N_CW (bmu_pkg::N_CW),
  .BM_W (BM_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .bm_par    (bm_par),
  .ser_bits  (ser_bits),
  .ser_first (ser_first)
);

// File: tb/soft_bmu_tb_top.sv
module soft_bmu_tb_top;
  localparam int SYM_W = 3;
  localparam int BM_W  = 5;
  localparam int N_CW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [SYM_W-1:0] sym0 = '0, sym1 = '0, sym2 = '0;
  logic [N_CW*BM_W-1:0] bm_par;
  logic [N_CW-1:0] ser_bits;
  logic ser_first;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmp_en = 0;

  // behavioural model state
  int exp_par [N_CW];
  int word    [N_CW];
  int bitpos = 5;
  int exp_first = 0;

  always #5 clk = ~clk;

  soft_bmu #(.SYM_W(SYM_W), .BM_W(BM_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .sym0(sym0), .sym1(sym1), .sym2(sym2),
    .bm_par(bm_par), .ser_bits(ser_bits), .ser_first(ser_first)
  );

  function automatic int sval(input logic [SYM_W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int ref_metric(input int s0, input int s1, input int s2, input int code);
    int s [3];
    int m = 0;
    s[0] = s0; s[1] = s1; s[2] = s2;
    for (int k = 0; k < 3; k++) m += ((code >> k) & 1) ? -s[k] : s[k];
    return m;
  endfunction

  function automatic int par_of(input int c);
    return int'($signed(bm_par[c*BM_W +: BM_W]));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // model steps on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < N_CW; c++) exp_par[c] = 0;
      bitpos = 5;
      exp_first = 0;
    end else if (in_valid) begin
      for (int c = 0; c < N_CW; c++) begin
        exp_par[c] = ref_metric(sval(sym0), sval(sym1), sval(sym2), c);
        word[c] = exp_par[c];
      end
      bitpos = 0;
      exp_first = 1;
    end else begin
      if (bitpos < 5) bitpos++;
      exp_first = 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int c = 0; c < N_CW; c++) begin
        chk("R1 parallel metric", par_of(c), exp_par[c]);
        chk("R3 mirror pair", par_of(c) + par_of(N_CW-1-c), 0);
        if (bitpos < 5)
          chk("R4 serial bit", int'(ser_bits[c]), (word[c] >>> bitpos) & 1);
        else
          chk("R6 idle serial", int'(ser_bits[c]), 0);
      end
      chk("R5 first strobe", int'(ser_first), exp_first);
    end
  end

  task automatic drive(input bit v, input int a, input int b, input int c);
    @(negedge clk);
    in_valid = v;
    sym0 = SYM_W'(a);
    sym1 = SYM_W'(b);
    sym2 = SYM_W'(c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state, still reflecting the reset edges
    for (int c = 0; c < N_CW; c++) chk("R8 reset metric", par_of(c), 0);
    chk("R8 reset serial", int'(ser_bits), 0);
    chk("R8 reset strobe", int'(ser_first), 0);
    cmp_en = 1;

    // R1 R2 R4 R7: full sweep, steps every fifth cycle, noise on inputs while idle
    for (int a = -3; a <= 3; a++)
      for (int b = -3; b <= 3; b++)
        for (int d = -3; d <= 3; d++) begin
          drive(1, a, b, d);
          for (int g = 0; g < 4; g++) drive(0, -a + g, d - g, b + 1);
        end

    // R6: run idle past the end of the last word
    repeat (8) drive(0, 2, -2, 1);

    // R7: restart two cycles into a word
    drive(1, 3, 3, 3);
    drive(0, 0, 0, 0);
    drive(1, -3, 2, -1);
    drive(0, 1, 1, 1);
    chk("R7 restart strobe", int'(ser_first), 1);
    for (int c = 0; c < N_CW; c++)
      chk("R7 restart bit0", int'(ser_bits[c]), ref_metric(-3, 2, -1, c) & 1);
    repeat (6) drive(0, 0, 0, 0);

    // R9: out-of-range code 100 summed at face value
    drive(1, -4, -4, -4);
    drive(0, 0, 0, 0);
    chk("R9 all -4 codeword 0", par_of(0), -12);
    chk("R9 all -4 codeword 7", par_of(7), 12);
    repeat (6) drive(0, 0, 0, 0);

    // R8: reset in the middle of a word
    drive(1, 2, -1, 3);
    drive(0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < N_CW; c++) chk("R8 mid-word reset metric", par_of(c), 0);
    chk("R8 mid-word reset serial", int'(ser_bits), 0);
    chk("R8 mid-word reset strobe", int'(ser_first), 0);
    repeat (3) drive(0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule